// File: doc/BRIEF.md
# Stack Processor Fetch and Branch Sequencer

This block sequences a 16-bit, two-stack processor. It holds the program counter, reads opcode words from a program ROM and decodes them. It then issues one-cycle control strobes to the data stack, the return stack and the arithmetic unit, which sit outside the block. Opcodes that carry an inline operand word (a literal, or a branch, jump or call target) take a third cycle, in which the operand is read from the ROM at the address that follows the opcode.

The sequencer reads three things from the datapath: the top of the data stack, the top of the return stack and four button inputs. It uses them to resolve conditional branches, the counted-loop decrement-and-branch and subroutine return. The ROM is read asynchronously: the ROM word must reflect the address output in the same cycle. Opcodes below 0x40 that the sequencer does not handle itself are passed to the arithmetic unit as a 6-bit function code.

Top module: `stack_seq`

## Requirements
- R1: A synchronous active-high reset sets the ROM address to 0 and clears every strobe. The first opcode after reset is fetched from address 0, also when reset arrives in the middle of an instruction.
- R2: An opcode fetched from address a is followed, one cycle later, by the ROM address a+1. All strobes are low in that cycle. Every strobe is a single-cycle pulse, and it appears in the cycle in which the ROM address of the next fetch is presented.
- R3: Opcode 0x40 reads the next ROM word and presents it on lit_data. It pulses t_load with t_src = 1 (literal) and pulses ds_push. The next fetch is from a+2.
- R4: Opcode 0x41 continues at the operand address. Opcode 0x42 continues at the operand address only when tos is all zeros, and otherwise at a+2.
- R5: Opcode 0x43 pulses rs_dec. It continues at the operand address unless rtop equals 1 (the decremented count would be zero), in which case it continues at a+2.
- R6: Opcode 0x44 pulses rs_push with r_wdata = a+2 and continues at the operand address. Opcode 0x45 is a single-word opcode that pulses rs_pop and continues at the address held in rtop.
- R7: Opcodes 0x46..0x49 branch to the operand when btn[0]..btn[3] respectively is 0. Opcodes 0x4A..0x4D branch when btn[0]..btn[3] respectively is 1. A branch that is not taken continues at a+2.
- R8: The return-stack opcodes are single-word and produce these pulses:
  - 0x30: rs_push with r_wdata = tos, and ds_pop.
  - 0x31: rs_pop, ds_push and t_load with t_src = 2 (return stack).
  - 0x32: ds_push and t_load with t_src = 2.
  - 0x33: rs_pop.
- R9: Every opcode below 0x40, except 0x30..0x33, is single-word and pulses alu_go with fcode equal to opcode bits [5:0]. While t_load is low, t_src is 0.
- R10: Opcodes 0x4E..0xFF, and any word with a bit set in [15:8], are single-word, raise no strobe and continue at a+1. Only 0x40..0x44 and 0x46..0x4D take three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_data | input | 16 | Program ROM word at rom_addr |
| tos | input | 16 | Top of data stack |
| rtop | input | 16 | Top of return stack |
| btn | input | 4 | Button inputs, btn[0] is the first |
| rom_addr | output | 16 | Program counter / ROM address |
| alu_go | output | 1 | Arithmetic-unit operation pulse |
| fcode | output | 6 | Arithmetic function code, valid with alu_go |
| ds_push | output | 1 | Data-stack push pulse |
| ds_pop | output | 1 | Data-stack pop pulse |
| rs_push | output | 1 | Return-stack push pulse |
| rs_pop | output | 1 | Return-stack pop pulse |
| rs_dec | output | 1 | Return-stack top decrement pulse |
| t_load | output | 1 | Load top of data stack |
| t_src | output | 2 | Source for t_load: 1 literal, 2 return stack |
| lit_data | output | 16 | Literal value, valid with t_load and t_src = 1 |
| r_wdata | output | 16 | Value for the return stack, valid with rs_push |

## Verification
A wrong phase state shows up as a ROM address that fails to advance by exactly one after a fetch, or as a strobe during the decode cycle. Both can be seen one cycle after the fault. A corrupted program counter or a misjudged branch condition shows at the next fetch address, two or three cycles after the opcode. A mis-decoded opcode shows as a wrong strobe set, or as a wrong instruction length, in the same cycle. Random instruction streams are mixed with the edge values of the conditions: rtop of 0 and 1, tos of zero, and each button at each level.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPERAND
  } phase_e;

  typedef enum logic [3:0] {
    K_NONE,
    K_ALU,
    K_TO_R,
    K_R_FROM,
    K_R_COPY,
    K_R_DROP,
    K_LIT,
    K_JMP,
    K_JZ,
    K_LOOP,
    K_CALL,
    K_RET,
    K_BTN_LO,
    K_BTN_HI
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic        two_word;
    logic [5:0]  fcode;
    logic [1:0]  bsel;
  } dec_t;

  localparam logic [1:0] TSRC_NONE = 2'd0;
  localparam logic [1:0] TSRC_LIT  = 2'd1;
  localparam logic [1:0] TSRC_RET  = 2'd2;

endpackage

// File: rtl/stack_seq_decode.sv
module stack_seq_decode
  import stack_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] ir,
  output dec_t          dec
);

  always_comb begin
    dec.kind     = K_NONE;
    dec.two_word = 1'b0;
    dec.fcode    = ir[5:0];
    dec.bsel     = ir[1:0] + 2'd2;
    if (ir[DW-1:8] == '0) begin
      if (ir[7:0] < 8'h40) begin
        case (ir[7:0])
          8'h30:   dec.kind = K_TO_R;
          8'h31:   dec.kind = K_R_FROM;
          8'h32:   dec.kind = K_R_COPY;
          8'h33:   dec.kind = K_R_DROP;
          default: dec.kind = K_ALU;
        endcase
      end else begin
        case (ir[7:0])
          8'h40: begin dec.kind = K_LIT;  dec.two_word = 1'b1; end
          8'h41: begin dec.kind = K_JMP;  dec.two_word = 1'b1; end
          8'h42: begin dec.kind = K_JZ;   dec.two_word = 1'b1; end
          8'h43: begin dec.kind = K_LOOP; dec.two_word = 1'b1; end
          8'h44: begin dec.kind = K_CALL; dec.two_word = 1'b1; end
          8'h45: dec.kind = K_RET;
          8'h46, 8'h47, 8'h48, 8'h49: begin
            dec.kind = K_BTN_LO; dec.two_word = 1'b1;
          end
          8'h4A, 8'h4B, 8'h4C, 8'h4D: begin
            dec.kind = K_BTN_HI; dec.two_word = 1'b1;
          end
          default: dec.kind = K_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/stack_seq_branch.sv
module stack_seq_branch
  import stack_seq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NBTN = 4
) (
  input  kind_e           kind,
  input  logic [1:0]      bsel,
  input  logic [DW-1:0]   tos,
  input  logic [DW-1:0]   rtop,
  input  logic [NBTN-1:0] btn,
  output logic            taken
);

  logic btn_bit;

  always_comb begin
    btn_bit = 1'b0;
    for (int i = 0; i < NBTN; i++) begin
      if (int'(bsel) == i) btn_bit = btn[i];
    end
  end

  always_comb begin
    case (kind)
      K_JMP, K_CALL: taken = 1'b1;
      K_JZ:          taken = (tos == '0);
      K_LOOP:        taken = (rtop != DW'(1));
      K_BTN_LO:      taken = ~btn_bit;
      K_BTN_HI:      taken = btn_bit;
      default:       taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NBTN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   rom_data,
  input  logic [DW-1:0]   tos,
  input  logic [DW-1:0]   rtop,
  input  logic [NBTN-1:0] btn,
  output logic [AW-1:0]   rom_addr,
  output logic            alu_go,
  output logic [5:0]      fcode,
  output logic            ds_push,
  output logic            ds_pop,
  output logic            rs_push,
  output logic            rs_pop,
  output logic            rs_dec,
  output logic            t_load,
  output logic [1:0]      t_src,
  output logic [DW-1:0]   lit_data,
  output logic [DW-1:0]   r_wdata
);

  phase_e        phase;
  logic [AW-1:0] pc;
  logic [AW-1:0] pc_inc;
  logic [DW-1:0] ir;
  dec_t          dec;
  logic          taken;

  assign pc_inc   = pc + 1'b1;
  assign rom_addr = pc;

  stack_seq_decode #(.DW(DW)) decode_i (
    .ir  (ir),
    .dec (dec)
  );

  stack_seq_branch #(.DW(DW), .NBTN(NBTN)) branch_i (
    .kind  (dec.kind),
    .bsel  (dec.bsel),
    .tos   (tos),
    .rtop  (rtop),
    .btn   (btn),
    .taken (taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= ST_FETCH;
      pc       <= '0;
      ir       <= '0;
      alu_go   <= 1'b0;
      fcode    <= '0;
      ds_push  <= 1'b0;
      ds_pop   <= 1'b0;
      rs_push  <= 1'b0;
      rs_pop   <= 1'b0;
      rs_dec   <= 1'b0;
      t_load   <= 1'b0;
      t_src    <= TSRC_NONE;
      lit_data <= '0;
      r_wdata  <= '0;
    end else begin
      alu_go  <= 1'b0;
      ds_push <= 1'b0;
      ds_pop  <= 1'b0;
      rs_push <= 1'b0;
      rs_pop  <= 1'b0;
      rs_dec  <= 1'b0;
      t_load  <= 1'b0;
      t_src   <= TSRC_NONE;
      case (phase)
        ST_FETCH: begin
          ir    <= rom_data;
          pc    <= pc_inc;
          phase <= ST_DECODE;
        end
        ST_DECODE: begin
          if (dec.two_word) begin
            phase <= ST_OPERAND;
          end else begin
            phase <= ST_FETCH;
            case (dec.kind)
              K_ALU: begin
                alu_go <= 1'b1;
                fcode  <= dec.fcode;
              end
              K_TO_R: begin
                rs_push <= 1'b1;
                ds_pop  <= 1'b1;
                r_wdata <= tos;
              end
              K_R_FROM: begin
                rs_pop  <= 1'b1;
                ds_push <= 1'b1;
                t_load  <= 1'b1;
                t_src   <= TSRC_RET;
              end
              K_R_COPY: begin
                ds_push <= 1'b1;
                t_load  <= 1'b1;
                t_src   <= TSRC_RET;
              end
              K_R_DROP: rs_pop <= 1'b1;
              K_RET: begin
                rs_pop <= 1'b1;
                pc     <= rtop[AW-1:0];
              end
              default: ;
            endcase
          end
        end
        ST_OPERAND: begin
          phase <= ST_FETCH;
          pc    <= taken ? rom_data[AW-1:0] : pc_inc;
          case (dec.kind)
            K_LIT: begin
              t_load   <= 1'b1;
              t_src    <= TSRC_LIT;
              ds_push  <= 1'b1;
              lit_data <= rom_data;
            end
            K_LOOP: rs_dec <= 1'b1;
            K_CALL: begin
              rs_push <= 1'b1;
              r_wdata <= DW'(pc_inc);
            end
            default: ;
          endcase
        end
        default: phase <= ST_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq_checker.sv
module stack_seq_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rom_addr,
  input logic          alu_go,
  input logic          ds_push,
  input logic          ds_pop,
  input logic          rs_push,
  input logic          rs_pop,
  input logic          rs_dec,
  input logic          t_load,
  input logic [1:0]    t_src
);

  logic any_strobe;
  assign any_strobe = alu_go | ds_push | ds_pop | rs_push | rs_pop | rs_dec | t_load;

  AST_RESET_ADDR_ZERO: assert property (@(posedge clk) rst |=> (rom_addr == '0)); // R1

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !any_strobe); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    any_strobe |=> !any_strobe); // R2

  AST_TSRC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !t_load |-> (t_src == 2'd0)); // R9

  AST_TSRC_VALID: assert property (@(posedge clk) disable iff (rst)
    t_load |-> (t_src == 2'd1 || t_src == 2'd2)); // R3

  AST_RSTACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({rs_push, rs_pop, rs_dec}) <= 1); // R8

  AST_ALU_ALONE: assert property (@(posedge clk) disable iff (rst)
    alu_go |-> !(rs_push | rs_pop | rs_dec | t_load | ds_push | ds_pop)); // R9

  AST_LOOP_ALONE: assert property (@(posedge clk) disable iff (rst)
    rs_dec |-> !(ds_push | ds_pop | t_load)); // R5

endmodule

bind stack_seq stack_seq_checker #(.AW(AW)) checker_i (
  .clk      (clk),
  .rst      (rst),
  .rom_addr (rom_addr),
  .alu_go   (alu_go),
  .ds_push  (ds_push),
  .ds_pop   (ds_pop),
  .rs_push  (rs_push),
  .rs_pop   (rs_pop),
  .rs_dec   (rs_dec),
  .t_load   (t_load),
  .t_src    (t_src)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rom_data;
  logic [15:0] tos  = '0;
  logic [15:0] rtop = '0;
  logic [3:0]  btn  = '0;
  logic [15:0] rom_addr;
  logic        alu_go, ds_push, ds_pop, rs_push, rs_pop, rs_dec, t_load;
  logic [5:0]  fcode;
  logic [1:0]  t_src;
  logic [15:0] lit_data, r_wdata;

  logic [15:0] rom [256];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_pc;

  assign rom_data = rom[rom_addr[7:0]];

  always #10 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst(rst), .rom_data(rom_data), .tos(tos), .rtop(rtop), .btn(btn),
    .rom_addr(rom_addr), .alu_go(alu_go), .fcode(fcode), .ds_push(ds_push),
    .ds_pop(ds_pop), .rs_push(rs_push), .rs_pop(rs_pop), .rs_dec(rs_dec),
    .t_load(t_load), .t_src(t_src), .lit_data(lit_data), .r_wdata(r_wdata)
  );

  // strobe vector: {alu_go, ds_push, ds_pop, rs_push, rs_pop, rs_dec, t_load, t_src[1:0]}
  function automatic logic [8:0] strobes_now();
    return {alu_go, ds_push, ds_pop, rs_push, rs_pop, rs_dec, t_load, t_src};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [15:0] op);
    if (op[15:8] != 0) return "R10";
    if (op[7:0] < 8'h30 || (op[7:0] >= 8'h34 && op[7:0] < 8'h40)) return "R9";
    if (op[7:0] < 8'h34) return "R8";
    case (op[7:0])
      8'h40: return "R3";
      8'h41, 8'h42: return "R4";
      8'h43: return "R5";
      8'h44, 8'h45: return "R6";
      default: return (op[7:0] <= 8'h4D) ? "R7" : "R10";
    endcase
  endfunction

  // Expected result of one instruction at address a.
  task automatic model(input logic [15:0] op, input logic [15:0] opnd,
                       input logic [15:0] a, input logic [15:0] t,
                       input logic [15:0] r, input logic [3:0] b,
                       output bit two, output logic [15:0] npc,
                       output logic [8:0] stb, output logic [15:0] rwd);
    logic [7:0] c;
    c   = op[7:0];
    two = 1'b0;
    npc = a + 16'd1;
    stb = '0;
    rwd = '0;
    if (op[15:8] == 0) begin
      if (c < 8'h40 && !(c >= 8'h30 && c <= 8'h33)) stb = 9'b1_0000_0000;
      else if (c == 8'h30) begin stb = 9'b0_0110_0000; rwd = t; end
      else if (c == 8'h31) stb = 9'b0_1001_0110;
      else if (c == 8'h32) stb = 9'b0_1000_0110;
      else if (c == 8'h33) stb = 9'b0_0001_0000;
      else if (c == 8'h45) begin stb = 9'b0_0001_0000; npc = r; end
      else if (c >= 8'h40 && c <= 8'h4D) begin
        bit tk;
        two = 1'b1;
        npc = a + 16'd2;
        tk  = 1'b0;
        case (c)
          8'h40: stb = 9'b0_1000_0101;
          8'h41: tk = 1'b1;
          8'h42: tk = (t == 0);
          8'h43: begin stb = 9'b0_0000_1000; tk = (r != 16'd1); end
          8'h44: begin stb = 9'b0_0010_0000; rwd = a + 16'd2; tk = 1'b1; end
          default: begin
            if (c <= 8'h49) tk = !b[c - 8'h46];
            else            tk = b[c - 8'h4A];
          end
        endcase
        if (tk) npc = opnd;
      end
    end
  endtask

  // Called just after a negedge in a fetch cycle.
  task automatic run_instr(input logic [15:0] op, input logic [15:0] opnd,
                           input logic [15:0] t, input logic [15:0] r,
                           input logic [3:0] b);
    bit two;
    logic [15:0] npc, rwd, a;
    logic [8:0] stb;
    string req;
    a = exp_pc;
    req = req_of(op);
    rom[a[7:0]] = op;
    rom[8'(a[7:0] + 8'd1)] = opnd;
    tos = t; rtop = r; btn = b;
    model(op, opnd, a, t, r, b, two, npc, stb, rwd);
    @(negedge clk);
    check(rom_addr == a + 16'd1, "R2", "address after fetch", 32'(rom_addr), 32'(a + 16'd1));
    check(strobes_now() == 0, "R2", "strobes in decode cycle", 32'(strobes_now()), 0);
    if (two) begin
      @(negedge clk);
      check(strobes_now() == 0, "R10", "strobes in operand cycle", 32'(strobes_now()), 0);
    end
    @(negedge clk);
    check(rom_addr == npc, req, $sformatf("next address op %h", op), 32'(rom_addr), 32'(npc));
    check(strobes_now() == stb, req, $sformatf("strobes op %h", op), 32'(strobes_now()), 32'(stb));
    if (stb[8])
      check(fcode == op[5:0], "R9", "fcode", 32'(fcode), 32'(op[5:0]));
    if (stb[5])
      check(r_wdata == rwd, req, "r_wdata", 32'(r_wdata), 32'(rwd));
    if (stb[2] && stb[1:0] == 2'd1)
      check(lit_data == opnd, "R3", "lit_data", 32'(lit_data), 32'(opnd));
    exp_pc = npc;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    check(rom_addr == 0, "R1", "address in reset", 32'(rom_addr), 0);
    check(strobes_now() == 0, "R1", "strobes in reset", 32'(strobes_now()), 0);
    @(negedge clk);
    rst = 1'b0;
    exp_pc = '0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 16'h00FF;
    void'($urandom(32'h0bad_5eed));
    @(negedge clk);
    do_reset();
    // directed corner cases
    run_instr(16'h0040, 16'hBEEF, 16'h0, 16'h0, 4'h0);   // R3 literal
    run_instr(16'h0041, 16'h0020, 16'h0, 16'h0, 4'h0);   // R4 jump
    run_instr(16'h0042, 16'h0050, 16'h0000, 16'h0, 4'h0); // R4 taken
    run_instr(16'h0042, 16'h0010, 16'h8000, 16'h0, 4'h0); // R4 not taken
    run_instr(16'h0043, 16'h0030, 16'h0, 16'h0001, 4'h0); // R5 falls through
    run_instr(16'h0043, 16'h0030, 16'h0, 16'h0000, 4'h0); // R5 wraps, jumps
    run_instr(16'h0043, 16'h0060, 16'h0, 16'h0005, 4'h0); // R5 jumps
    run_instr(16'h0044, 16'h0090, 16'h0, 16'h0, 4'h0);   // R6 call
    run_instr(16'h0045, 16'h0000, 16'h0, 16'h0062, 4'h0); // R6 return
    for (int k = 0; k < 4; k++) begin                      // R7 every button, both levels
      run_instr(16'h0046 + 16'(k), 16'h00A0, 16'h0, 16'h0, 4'hF);
      run_instr(16'h0046 + 16'(k), 16'h00A8, 16'h0, 16'h0, ~(4'h1 << k));
      run_instr(16'h004A + 16'(k), 16'h00B0, 16'h0, 16'h0, 4'h1 << k);
      run_instr(16'h004A + 16'(k), 16'h00B8, 16'h0, 16'h0, ~(4'h1 << k));
    end
    for (int k = 0; k < 4; k++)                             // R8
      run_instr(16'h0030 + 16'(k), 16'h0, 16'h1234, 16'h0, 4'h0);
    run_instr(16'h0000, 16'h0, 16'h0, 16'h0, 4'h0);      // R9 no-op code to ALU
    run_instr(16'h001D, 16'h0, 16'h0, 16'h0, 4'h0);      // R9
    run_instr(16'h0039, 16'h0, 16'h0, 16'h0, 4'h0);      // R9
    run_instr(16'h004E, 16'h0041, 16'h0, 16'h0, 4'h0);   // R10
    run_instr(16'h0140, 16'h0041, 16'h0, 16'h0, 4'h0);   // R10 high byte set
    // random instruction stream
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] op, opnd, t, r;
      int sel;
      sel  = $urandom_range(0, 9);
      opnd = 16'($urandom_range(0, 255));
      t    = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      r    = 16'($urandom_range(0, 3));
      if (sel < 5)       op = 16'h0040 + 16'($urandom_range(0, 13));
      else if (sel < 7)  op = 16'($urandom_range(0, 63));
      else if (sel < 9)  op = 16'h0030 + 16'($urandom_range(0, 3));
      else               op = 16'($urandom_range(16'h4E, 16'h3FF));
      if (op == 16'h0045) r = 16'($urandom_range(0, 255));
      run_instr(op, opnd, t, r, 4'($urandom));
    end
    // R1 reset during an operand instruction
    rom[exp_pc[7:0]] = 16'h0041;
    rom[8'(exp_pc[7:0] + 8'd1)] = 16'h0077;
    @(negedge clk);
    do_reset();
    run_instr(16'h0040, 16'h5A5A, 16'h0, 16'h0, 4'h0);   // R1 first fetch from 0
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule